// File: doc/BRIEF.md
# Bus Interface Diagnostic Control Register

This block is the diagnostic control register of a node's interface to a shared multiprocessor bus. Software writes it through a plain register port to take the node off the bus and to bring it back. The block can also raise a bus fault at the moment the isolation ends. A third use is to schedule one-shot accesses to the duplicate-tag store of either of two CPUs.

Isolation is on when reset ends. While the node is isolated it ignores all bus traffic, keeps its own outgoing transactions off the bus, loops them back to its bus interface inputs, and withdraws from arbitration. The single `isolate` output drives all four of these actions.

A tag access is armed by a register write and is carried out by the next memory-space read the node observes. The index of that read chooses the tag entry. For a tag read, the block pulses a read strobe and the capture enables of the tag data and tag status holding registers. For a tag write, it pulses a write strobe, and the tag store takes the contents of those holding registers. The tag store, the arbiter and the ECC path sit outside this block.

Top module: `bdiag_ctrl`

## Requirements
- R1: After reset, `isolate` is 1, fault enable and CPU select are 0, `reg_rdata` reads 0x0001, and `fault_pulse`, `tag_rd_stb`, `tag_wr_stb`, `cap_data` and `cap_stat` are 0.
- R2: Register fields are bit 0 isolate, bit 1 fault enable and bit 2 CPU select. They read back as written. Bits 3 and 4 arm a tag read and a tag write and always read 0. Every other bit, including the reserved ones, is ignored on write and reads 0.
- R3: `isolate` takes the value of written bit 0 on the clock edge that accepts the write.
- R4: `fault_pulse` is high for exactly one cycle, starting at the edge that accepts a write which changes isolate from 1 to 0 with written bit 1 set. In every other case it stays 0.
- R5: An armed tag read is executed by the next cycle with `mem_rd_vld` high. At the following edge, `tag_rd_stb`, `cap_data` and `cap_stat` go high for one cycle. In that same cycle `tag_idx` equals that read's `mem_rd_idx`, and `tag_cpu` equals the CPU select bit as it was during the read (0 for CPU0, 1 for CPU1).
- R6: An armed tag write is executed in the same way as R5, but it raises `tag_wr_stb` instead of `tag_rd_stb`, `cap_data` and `cap_stat`.
- R7: When a tag read and a tag write are both armed, the next memory-space read performs only the tag write, and the tag read is dropped.
- R8: An arm persists through any number of idle cycles. It is cleared by the read that executes it, so a second read produces no strobe.
- R9: Tag access needs isolation. An arm bit written while written bit 0 is 0 is ignored. A write that clears isolate discards any pending arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| mem_rd_vld | input | 1 | A memory-space read is observed this cycle |
| mem_rd_idx | input | IDX_W | Tag index of that read |
| isolate | output | 1 | Ignore bus, loop back, leave arbitration |
| fault_pulse | output | 1 | One-cycle bus fault request |
| tag_rd_stb | output | 1 | Tag entry read strobe |
| tag_wr_stb | output | 1 | Tag entry write strobe |
| tag_cpu | output | 1 | Target CPU of the tag access |
| tag_idx | output | IDX_W | Tag entry index |
| cap_data | output | 1 | Capture enable, tag data holding register |
| cap_stat | output | 1 | Capture enable, tag status holding register |

## Verification
The situation hardest to reach from the ports is a tag access that actually executes. It needs isolation to be set in, or before, the arming write, and it then needs a memory-space read. A fault, by contrast, needs isolate to drop from 1 while the enable is set. The bench therefore writes an isolated, fault-disabled base state before each swept value. It then sweeps every combination of the low eight write bits, with the reserved upper bits mirrored, and follows each value with two memory-space reads. Separate sequences cover arms that wait through idle cycles and arms that are discarded when isolation drops.

// File: rtl/bdiag_pkg.sv
package bdiag_pkg;
  localparam int ISO_BIT = 0;
  localparam int FEN_BIT = 1;
  localparam int CPU_BIT = 2;
  localparam int ARD_BIT = 3;
  localparam int AWR_BIT = 4;
  localparam int MIN_W   = 5;

  typedef struct packed {
    logic cpu;
    logic fen;
    logic iso;
  } ctrl_t;
endpackage

// File: rtl/bdiag_rst_sync.sv
module bdiag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bdiag_ctrl_reg.sv
module bdiag_ctrl_reg
  import bdiag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_d,
  output logic              arm_rd_req,
  output logic              arm_wr_req,
  output logic [DATA_W-1:0] rdata
);
  logic unused_wbits;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.iso = wdata[ISO_BIT];
      ctrl_d.fen = wdata[FEN_BIT];
      ctrl_d.cpu = wdata[CPU_BIT];
    end
  end

  assign arm_rd_req   = wr_en & wdata[ARD_BIT] & wdata[ISO_BIT];
  assign arm_wr_req   = wr_en & wdata[AWR_BIT] & wdata[ISO_BIT];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.iso <= 1'b1;
      ctrl_q.fen <= 1'b0;
      ctrl_q.cpu <= 1'b0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata          = '0;
    rdata[ISO_BIT] = ctrl_q.iso;
    rdata[FEN_BIT] = ctrl_q.fen;
    rdata[CPU_BIT] = ctrl_q.cpu;
  end
endmodule

// File: rtl/bdiag_fault_gen.sv
module bdiag_fault_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic iso_q,
  input  logic iso_d,
  input  logic fen_d,
  output logic fault_pulse
);
  logic fault_d;

  always_comb begin
    fault_d = iso_q & ~iso_d & fen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_pulse <= 1'b0;
    else        fault_pulse <= fault_d;
  end
endmodule

// File: rtl/bdiag_tag_seq.sv
module bdiag_tag_seq #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iso_d,
  input  logic             arm_rd_req,
  input  logic             arm_wr_req,
  input  logic             cpu_q,
  input  logic             mem_rd_vld,
  input  logic [IDX_W-1:0] mem_rd_idx,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             stb_cpu,
  output logic [IDX_W-1:0] stb_idx
);
  logic arm_rd_q, arm_wr_q, arm_rd_d, arm_wr_d;
  logic consume, exec_rd, exec_wr;

  always_comb begin
    consume = mem_rd_vld & (arm_rd_q | arm_wr_q);
    exec_wr = mem_rd_vld & arm_wr_q;
    exec_rd = mem_rd_vld & arm_rd_q & ~arm_wr_q;

    arm_rd_d = arm_rd_q;
    arm_wr_d = arm_wr_q;
    if (consume) begin
      arm_rd_d = 1'b0;
      arm_wr_d = 1'b0;
    end
    if (arm_rd_req) arm_rd_d = 1'b1;
    if (arm_wr_req) arm_wr_d = 1'b1;
    if (!iso_d) begin
      arm_rd_d = 1'b0;
      arm_wr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_rd_q <= 1'b0;
      arm_wr_q <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
    end else begin
      arm_rd_q <= arm_rd_d;
      arm_wr_q <= arm_wr_d;
      rd_stb   <= exec_rd;
      wr_stb   <= exec_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_cpu <= 1'b0;
      stb_idx <= '0;
    end else if (consume) begin
      stb_cpu <= cpu_q;
      stb_idx <= mem_rd_idx;
    end
  end
endmodule

// File: rtl/bdiag_ctrl.sv
module bdiag_ctrl
  import bdiag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mem_rd_vld,
  input  logic [IDX_W-1:0]  mem_rd_idx,
  output logic              isolate,
  output logic              fault_pulse,
  output logic              tag_rd_stb,
  output logic              tag_wr_stb,
  output logic              tag_cpu,
  output logic [IDX_W-1:0]  tag_idx,
  output logic              cap_data,
  output logic              cap_stat
);
  ctrl_t ctrl_q, ctrl_d;
  logic  rst_n_sync, arm_rd_req, arm_wr_req;

  initial begin
    if (DATA_W < MIN_W) $error("DATA_W too small");
  end

  bdiag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  bdiag_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(reg_wr), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .ctrl_d(ctrl_d), .arm_rd_req(arm_rd_req),
    .arm_wr_req(arm_wr_req), .rdata(reg_rdata)
  );

  bdiag_fault_gen u_fault (
    .clk(clk), .rst_n(rst_n_sync), .iso_q(ctrl_q.iso), .iso_d(ctrl_d.iso),
    .fen_d(ctrl_d.fen), .fault_pulse(fault_pulse)
  );

  bdiag_tag_seq #(.IDX_W(IDX_W)) u_tag (
    .clk(clk), .rst_n(rst_n_sync), .iso_d(ctrl_d.iso),
    .arm_rd_req(arm_rd_req), .arm_wr_req(arm_wr_req), .cpu_q(ctrl_q.cpu),
    .mem_rd_vld(mem_rd_vld), .mem_rd_idx(mem_rd_idx),
    .rd_stb(tag_rd_stb), .wr_stb(tag_wr_stb), .stb_cpu(tag_cpu),
    .stb_idx(tag_idx)
  );

  assign isolate  = ctrl_q.iso;
  assign cap_data = tag_rd_stb;
  assign cap_stat = tag_rd_stb;
endmodule

// File: rtl/bdiag_ctrl_chk.sv
module bdiag_ctrl_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_rd_vld,
  input logic [IDX_W-1:0] mem_rd_idx,
  input logic             isolate,
  input logic             fault_pulse,
  input logic             tag_rd_stb,
  input logic             tag_wr_stb,
  input logic [IDX_W-1:0] tag_idx
);
  // R4
  fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  // R4
  fault_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> $fell(isolate));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_rd_stb && tag_wr_stb));

  // R9
  wr_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_wr_stb |-> ($past(mem_rd_vld) && $past(isolate)));

  // R5
  rd_needs_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_rd_stb |-> ($past(mem_rd_vld) && $past(isolate)));

  // R5
  idx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_rd_stb || tag_wr_stb) |-> (tag_idx == $past(mem_rd_idx)));

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_rd_stb || tag_wr_stb) |=> !(tag_rd_stb || tag_wr_stb) || $past(mem_rd_vld));
endmodule

bind bdiag_ctrl bdiag_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd_vld(mem_rd_vld), .mem_rd_idx(mem_rd_idx),
  .isolate(isolate), .fault_pulse(fault_pulse), .tag_rd_stb(tag_rd_stb),
  .tag_wr_stb(tag_wr_stb), .tag_idx(tag_idx)
);

// File: tb/bdiag_ctrl_tb.sv
module bdiag_ctrl_tb;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              mem_rd_vld = 1'b0;
  logic [IDX_W-1:0]  mem_rd_idx = '0;
  logic              isolate, fault_pulse, tag_rd_stb, tag_wr_stb, tag_cpu;
  logic [IDX_W-1:0]  tag_idx;
  logic              cap_data, cap_stat;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bdiag_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_rd_vld(mem_rd_vld), .mem_rd_idx(mem_rd_idx),
    .isolate(isolate), .fault_pulse(fault_pulse), .tag_rd_stb(tag_rd_stb),
    .tag_wr_stb(tag_wr_stb), .tag_cpu(tag_cpu), .tag_idx(tag_idx),
    .cap_data(cap_data), .cap_stat(cap_stat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [DATA_W-1:0] v);
    reg_wr    = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic mrd(input logic [IDX_W-1:0] idx);
    mem_rd_vld = 1'b1;
    mem_rd_idx = idx;
    @(negedge clk);
    mem_rd_vld = 1'b0;
  endtask

  task automatic chk_stb(input string req, input logic er, input logic ew);
    chk(req, "tag_rd_stb", int'(tag_rd_stb), int'(er));
    chk(req, "tag_wr_stb", int'(tag_wr_stb), int'(ew));
    chk(req, "cap_data", int'(cap_data), int'(er));
    chk(req, "cap_stat", int'(cap_stat), int'(er));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "rdata", int'(reg_rdata), 1);
    chk("R1", "isolate", int'(isolate), 1);
    chk("R1", "fault", int'(fault_pulse), 0);
    chk_stb("R1", 1'b0, 1'b0);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      logic       er, ew;
      b = v[7:0];
      wr(16'h0001);
      @(negedge clk);
      wr({b, b});
      // R2 R3 R4 after the accepting edge
      chk("R2", "rdata", int'(reg_rdata), int'(b & 8'h07));
      chk("R3", "isolate", int'(isolate), int'(b[0]));
      chk("R4", "fault", int'(fault_pulse), int'(!b[0] && b[1]));
      ew = b[0] & b[4];
      er = b[0] & b[3] & ~b[4];
      mrd(b ^ 8'h5A);
      // R5 R6 R7 R9 execution
      chk("R4", "fault end", int'(fault_pulse), 0);
      chk_stb(b[4] ? "R6" : "R5", er, ew);
      if (er || ew) begin
        chk("R5", "tag_idx", int'(tag_idx), int'(b ^ 8'h5A));
        chk("R5", "tag_cpu", int'(tag_cpu), int'(b[2]));
      end
      mrd(b);
      // R8 self clear
      chk_stb("R8", 1'b0, 1'b0);
    end

    // R8 arm waits through idle cycles
    wr(16'h000D);
    repeat (6) @(negedge clk);
    chk_stb("R8", 1'b0, 1'b0);
    mrd(8'hC3);
    chk_stb("R8", 1'b1, 1'b0);
    chk("R8", "tag_idx", int'(tag_idx), 8'hC3);
    chk("R5", "tag_cpu", int'(tag_cpu), 1);

    // R9 dropping isolation discards a pending arm
    wr(16'h0011);
    wr(16'h0000);
    chk("R9", "isolate", int'(isolate), 0);
    wr(16'h0001);
    mrd(8'h11);
    chk_stb("R9", 1'b0, 1'b0);

    // R7 both armed, then a second read shows the dropped read
    wr(16'h0019);
    mrd(8'h22);
    chk_stb("R7", 1'b0, 1'b1);
    mrd(8'h23);
    chk_stb("R7", 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule